// File: doc/BRIEF.md
# Ternary Match Table with Entry Aging

This block is a small ternary lookup table. Each entry holds a value and a per-bit care mask, so a position whose care bit is 0 matches either comparand value. Beside the value, each entry carries four status flags: Empty, Skip, Permanent and Age. A host drives single-cycle commands on one port and reads a registered result one cycle later. Every search reports the lowest-indexed matching entry and marks that entry as recently used.

The status flags support three table-upkeep functions. The host can walk through several matches of one key by stepping past each reported entry. A sweep command purges entries that have not been used since the previous sweep, unless they are pinned. A learn command inserts a key that missed into the first free slot, which is the usual way a bridge fills its address table.

Top module: `tcam_age`

## Requirements
- R1: After reset every entry is empty with Skip, Permanent and Age clear. A read (op 2) returns status `{empty,skip,perm,age}` on `res_status[3:0]`, which is 4'b1000 for a reset entry.
- R2: In a search (op 3), bit j of an entry takes part in the compare only when its care bit j is 1. An entry matches when every cared bit equals the comparand.
- R3: Empty entries never match, and a reported hit always names a non-empty entry.
- R4: When several entries match, `res_addr` gives the lowest matching index. `res_hit` is 0 when nothing matches.
- R5: A search or learn that hits sets the Age flag of the reported entry.
- R6: Next-match (op 4) sets Skip on the entry reported by the immediately preceding search or next-match, if that command hit, and then searches again. Entries with Skip set never match. Clear-skip (op 7) resets every Skip flag.
- R7: Sweep (op 5) empties every non-empty entry whose Permanent and Age flags are both 0, and clears Age on all entries. An entry with Permanent set is never emptied by a sweep.
- R8: Learn (op 6) on a hit behaves like a search. On a miss it stores the comparand with all care bits set in the lowest empty entry, returns that index with `res_hit`=0, or raises `res_full` when no entry is empty. `res_hit` and `res_full` are never both 1.
- R9: `res_valid` is 1 in the cycle after an accepted command and 0 otherwise. All result fields change only with it.
- R10: Write (op 1) stores `cmd_key`, `cmd_care` and `cmd_perm` at `cmd_addr`, marks the entry non-empty and clears its Skip and Age flags. Read (op 2) returns the value, mask and status at `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 write, 2 read, 3 search, 4 next-match, 5 sweep, 6 learn, 7 clear-skip |
| cmd_addr | input | IDXW | Entry index for write and read |
| cmd_key | input | WIDTH | Value to write, or comparand |
| cmd_care | input | WIDTH | Care mask for write |
| cmd_perm | input | 1 | Permanent flag for write |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Search or learn found a match |
| res_full | output | 1 | Learn missed and no entry was empty |
| res_addr | output | IDXW | Hit index, learned index or written index |
| res_key | output | WIDTH | Value read |
| res_care | output | WIDTH | Mask read |
| res_status | output | 4 | {empty, skip, perm, age} read |

## Verification
Every command's result appears exactly one clock edge after the command is taken, and any state change the command causes is visible to a command issued in that same following cycle. The bench drives each command on a falling edge and holds it for one cycle. It compares the result fields at the next falling edge, half a period after the edge that registered them. Effects on status flags are checked through a read issued right after, whose result is due one cycle later again.

// File: rtl/tcam_age.sv
module tcam_age #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 32,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [IDXW-1:0]  cmd_addr,
  input  logic [WIDTH-1:0] cmd_key,
  input  logic [WIDTH-1:0] cmd_care,
  input  logic             cmd_perm,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_full,
  output logic [IDXW-1:0]  res_addr,
  output logic [WIDTH-1:0] res_key,
  output logic [WIDTH-1:0] res_care,
  output logic [3:0]       res_status
);
  localparam logic [2:0] OP_WR = 3'd1, OP_RD = 3'd2, OP_SRCH = 3'd3, OP_NEXT = 3'd4,
                         OP_SWEEP = 3'd5, OP_LEARN = 3'd6, OP_CLRSKIP = 3'd7;

  logic [WIDTH-1:0] key_q  [ENTRIES];
  logic [WIDTH-1:0] care_q [ENTRIES];
  logic [ENTRIES-1:0] empty_q, skip_q, perm_q, age_q, hit_vec;
  logic               last_ok;
  logic [IDXW-1:0]    last_idx, hit_idx, free_idx;
  logic               hit_any, free_any, step;

  assign step = cmd_op == OP_NEXT && last_ok;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      hit_vec[i] = !empty_q[i] && !skip_q[i] && !(step && last_idx == IDXW'(i)) &&
                   (((key_q[i] ^ cmd_key) & care_q[i]) == '0);
  end

  always_comb begin
    hit_idx = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDXW'(i);
      if (empty_q[i]) free_idx = IDXW'(i);
    end
  end

  assign hit_any  = |hit_vec;
  assign free_any = |empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i]  <= '0;
        care_q[i] <= '0;
      end
      empty_q <= '1; skip_q <= '0; perm_q <= '0; age_q <= '0;
      last_ok <= 1'b0; last_idx <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_full <= 1'b0; res_addr <= '0;
      res_key <= '0; res_care <= '0; res_status <= '0;
    end else begin
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        res_hit  <= 1'b0;
        res_full <= 1'b0;
        last_ok  <= 1'b0;
        case (cmd_op)
          OP_WR: begin
            key_q[cmd_addr]   <= cmd_key;
            care_q[cmd_addr]  <= cmd_care;
            perm_q[cmd_addr]  <= cmd_perm;
            empty_q[cmd_addr] <= 1'b0;
            skip_q[cmd_addr]  <= 1'b0;
            age_q[cmd_addr]   <= 1'b0;
            res_addr <= cmd_addr;
          end
          OP_RD: begin
            res_addr   <= cmd_addr;
            res_key    <= key_q[cmd_addr];
            res_care   <= care_q[cmd_addr];
            res_status <= {empty_q[cmd_addr], skip_q[cmd_addr], perm_q[cmd_addr], age_q[cmd_addr]};
          end
          OP_SRCH, OP_NEXT: begin
            if (step) skip_q[last_idx] <= 1'b1;
            res_hit  <= hit_any;
            res_addr <= hit_idx;
            last_ok  <= hit_any;
            last_idx <= hit_idx;
            if (hit_any) age_q[hit_idx] <= 1'b1;
          end
          OP_SWEEP: begin
            for (int i = 0; i < ENTRIES; i++)
              if (!empty_q[i] && !perm_q[i] && !age_q[i]) empty_q[i] <= 1'b1;
            age_q <= '0;
          end
          OP_LEARN: begin
            if (hit_any) begin
              res_hit  <= 1'b1;
              res_addr <= hit_idx;
              age_q[hit_idx] <= 1'b1;
            end else if (free_any) begin
              key_q[free_idx]   <= cmd_key;
              care_q[free_idx]  <= '1;
              perm_q[free_idx]  <= 1'b0;
              empty_q[free_idx] <= 1'b0;
              skip_q[free_idx]  <= 1'b0;
              age_q[free_idx]   <= 1'b0;
              res_addr <= free_idx;
            end else begin
              res_full <= 1'b1;
            end
          end
          OP_CLRSKIP: skip_q <= '0;
          default: ;
        endcase
      end
    end
  end

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> res_valid); // R9
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !res_valid); // R9
  AST_HIT_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(res_hit && res_full)); // R8
  AST_HIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_hit |-> !empty_q[res_addr]); // R3
  AST_AGE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) res_valid && res_hit |-> age_q[res_addr]); // R5
  AST_SKIP_ON_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && step |=> skip_q[$past(last_idx)]); // R6

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_PERM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_SWEEP && !empty_q[g] && perm_q[g] |=> !empty_q[g]); // R7
  end
endmodule

// File: tb/sim_tcam_age.sv
module sim_tcam_age;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, cmd_perm = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0] cmd_key = '0, cmd_care = '0;
  logic res_valid, res_hit, res_full;
  logic [AW-1:0] res_addr;
  logic [W-1:0] res_key, res_care;
  logic [3:0] res_status;
  int checks = 0, errors = 0;
  logic [W-1:0] mk [N];
  logic [W-1:0] mc [N];
  logic [N-1:0] mv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_age #(.ENTRIES(N), .WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_key(cmd_key), .cmd_care(cmd_care), .cmd_perm(cmd_perm), .res_valid(res_valid),
    .res_hit(res_hit), .res_full(res_full), .res_addr(res_addr), .res_key(res_key),
    .res_care(res_care), .res_status(res_status));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int addr, input int key, input int care, input logic perm);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr);
    cmd_key = W'(key); cmd_care = W'(care); cmd_perm = perm;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input int a, input int k, input int c, input logic p);
    cmd(3'd1, a, k, c, p);
    mk[a] = W'(k); mc[a] = W'(c); mv[a] = 1'b1;
  endtask

  task automatic load_table;
    wr(0, 8'h00, 8'hF0, 0); wr(1, 8'h35, 8'hFF, 0); wr(2, 8'h30, 8'hF0, 0);
    wr(3, 8'h80, 8'hC0, 0); wr(4, 8'h81, 8'h81, 0); wr(5, 8'h55, 8'hFF, 1);
    wr(6, 8'h0F, 8'h0F, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 res_valid after reset", res_valid, 0);
    for (int a = 0; a < N; a++) begin
      cmd(3'd2, a, 0, 0, 0);
      chk("R1 reset status", res_status, 4'b1000);
    end
    @(negedge clk);
    chk("R9 res_valid idle", res_valid, 0);
    cmd(3'd3, 0, 8'h00, 0, 0);
    chk("R3 empty table miss", res_hit, 0);
    chk("R9 res_valid after cmd", res_valid, 1);

    load_table();
    cmd(3'd2, 3, 0, 0, 0);
    chk("R10 read key", res_key, 8'h80);
    chk("R10 read care", res_care, 8'hC0);
    chk("R10 read status", res_status, 4'b0000);
    cmd(3'd2, 5, 0, 0, 0);
    chk("R10 read perm", res_status, 4'b0010);

    cmd(3'd3, 0, 8'h35, 0, 0);
    chk("R4 hit 0x35", res_hit, 1);
    chk("R4 addr 0x35", res_addr, 1);
    cmd(3'd2, 1, 0, 0, 0);
    chk("R5 age set", res_status, 4'b0001);

    cmd(3'd5, 0, 0, 0, 0);
    for (int a = 0; a < N; a++) begin
      cmd(3'd2, a, 0, 0, 0);
      chk("R7 sweep status", res_status, (a == 1) ? 4'b0000 : (a == 5) ? 4'b0010 : 4'b1000);
    end
    cmd(3'd3, 0, 8'h00, 0, 0);
    chk("R7 purged entry misses", res_hit, 0);
    cmd(3'd3, 0, 8'h55, 0, 0);
    chk("R7 permanent still hits", res_addr, 5);

    mv = '0;
    load_table();
    cmd(3'd7, 0, 0, 0, 0);
    for (int k = 0; k < 256; k++) begin
      int exp_idx;
      exp_idx = -1;
      for (int i = N - 1; i >= 0; i--)
        if (mv[i] && (((W'(k) ^ mk[i]) & mc[i]) == '0)) exp_idx = i;
      cmd(3'd3, 0, k, 0, 0);
      chk("R2 sweep hit", res_hit, exp_idx >= 0);
      if (exp_idx >= 0) chk("R4 sweep addr", res_addr, exp_idx);
    end

    cmd(3'd3, 0, 8'h81, 0, 0);
    chk("R6 first of multi", res_addr, 3);
    cmd(3'd4, 0, 8'h81, 0, 0);
    chk("R6 next hit", res_hit, 1);
    chk("R6 next addr", res_addr, 4);
    cmd(3'd4, 0, 8'h81, 0, 0);
    chk("R6 walk exhausted", res_hit, 0);
    cmd(3'd3, 0, 8'h80, 0, 0);
    chk("R6 skipped entry excluded", res_hit, 0);
    cmd(3'd2, 3, 0, 0, 0);
    chk("R6 skip flag", res_status[2], 1);
    cmd(3'd7, 0, 0, 0, 0);
    cmd(3'd3, 0, 8'h81, 0, 0);
    chk("R6 clear-skip restores", res_addr, 3);

    cmd(3'd6, 0, 8'h42, 0, 0);
    chk("R8 learn miss hit", res_hit, 0);
    chk("R8 learn full", res_full, 0);
    chk("R8 learn addr", res_addr, 7);
    cmd(3'd2, 7, 0, 0, 0);
    chk("R8 learned key", res_key, 8'h42);
    chk("R8 learned care", res_care, 8'hFF);
    cmd(3'd3, 0, 8'h42, 0, 0);
    chk("R8 learned entry hits", res_addr, 7);
    cmd(3'd6, 0, 8'h44, 0, 0);
    chk("R8 table full", res_full, 1);
    chk("R8 full no hit", res_hit, 0);
    cmd(3'd6, 0, 8'h35, 0, 0);
    chk("R8 learn on hit", res_hit, 1);
    chk("R8 learn hit addr", res_addr, 1);
    @(negedge clk);
    chk("R9 idle after cmd", res_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule